// File: doc/BRIEF.md
# Register Field with Hardware Set and Clear

This block is one storage field of a control/status register bank. Software reaches it through a plain strobe interface: a write strobe with data and a per-bit write mask, and a read strobe. Hardware reaches it through a data input qualified by a write-enable, and through two single-bit inputs. One forces every bit of the field to one. The other forces every bit to zero. The stored value is always visible both to software and to hardware logic.

Parameters fix the behaviour of each instance. They set the reset value and the polarity of the hardware write-enable. They decide which single-bit force input is present; when both are asked for, only the force-to-one input acts. They choose whether software or hardware wins when both update the field in the same cycle. Two further options are available: clearing the field as a side effect of a software read, and a single-pulse mode in which software-written bits last for one cycle only.

Top module: `reg_field`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the field is loaded with `RESET_VAL` on that edge.
- R2: A software write loads `sw_wdata` into the bits whose `sw_wmask` bit is 1. Bits with mask 0 keep their value unless another update applies to them.
- R3: `sw_rdata` and `hw_q` both equal the stored field value at all times.
- R4: The field loads `hw_wdata` when `hw_we` is 1 if `WE_ACTIVE_LOW` is 0, or when `hw_we` is 0 if `WE_ACTIVE_LOW` is 1.
- R5: With `HAS_SET`=1, a cycle with `hw_set`=1 loads all ones into the field.
- R6: With `HAS_CLR`=1 and `HAS_SET`=0, a cycle with `hw_clr`=1 loads all zeros. When `HAS_SET`=1, `hw_clr` has no effect.
- R7: With `SW_PRECEDENCE`=0, updates in the same cycle are applied in this order, and the last one wins: software write, read clear, hardware write, set/clear.
- R8: With `SW_PRECEDENCE`=1, updates are applied in this order, and the last one wins: hardware write, set/clear, software write, read clear. Bits outside the write mask still take the hardware result.
- R9: With `CLEAR_ON_READ`=1, a cycle with `sw_rd`=1 returns the current value and clears the field, in the position R7 or R8 gives it.
- R10: With `SINGLE_PULSE`=1, after every edge outside reset, each bit that software did not write with a mask bit of 1 in that cycle is 0. This overrides every hardware update.
- R11: In a cycle with no active update, the field keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sw_wr | input | 1 | Software write strobe |
| sw_wdata | input | WIDTH | Software write data |
| sw_wmask | input | WIDTH | Per-bit software write mask |
| sw_rd | input | 1 | Software read strobe |
| sw_rdata | output | WIDTH | Software read data |
| hw_we | input | 1 | Hardware write-enable, polarity set by parameter |
| hw_wdata | input | WIDTH | Hardware write data |
| hw_set | input | 1 | Force all bits to one |
| hw_clr | input | 1 | Force all bits to zero |
| hw_q | output | WIDTH | Field value for hardware |

## Verification
The assertions take only one thing for granted about the inputs: that they are valid binary values at every rising edge. They make no assumption that software and hardware stay apart. The bench drives all inputs at the falling edge from fixed-seed random draws and directed steps. It deliberately lets writes, reads, set and clear collide, so that the precedence order is exercised. Three instances with different parameter sets share that stimulus. One instance has the write-enable inverted at its pin, so both enable polarities see the same intent.

// File: rtl/reg_field.sv
module reg_field #(
  parameter int unsigned      WIDTH         = 8,
  parameter logic [WIDTH-1:0] RESET_VAL     = '0,
  parameter bit               SW_PRECEDENCE = 1'b0,
  parameter bit               HAS_SET       = 1'b1,
  parameter bit               HAS_CLR       = 1'b0,
  parameter bit               WE_ACTIVE_LOW = 1'b0,
  parameter bit               CLEAR_ON_READ = 1'b0,
  parameter bit               SINGLE_PULSE  = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_wr,
  input  logic [WIDTH-1:0] sw_wdata,
  input  logic [WIDTH-1:0] sw_wmask,
  input  logic             sw_rd,
  output logic [WIDTH-1:0] sw_rdata,
  input  logic             hw_we,
  input  logic [WIDTH-1:0] hw_wdata,
  input  logic             hw_set,
  input  logic             hw_clr,
  output logic [WIDTH-1:0] hw_q
);
  localparam bit CLR_LIVE = HAS_CLR && !HAS_SET;

  logic [WIDTH-1:0] q, d;
  logic we_hit, set_hit, clr_hit, rd_hit;

  assign we_hit  = hw_we ^ WE_ACTIVE_LOW;
  assign set_hit = HAS_SET && hw_set;
  assign clr_hit = CLR_LIVE && hw_clr;
  assign rd_hit  = CLEAR_ON_READ && sw_rd;

  always_comb begin
    d = q;
    if (SW_PRECEDENCE) begin
      if (we_hit)  d = hw_wdata;
      if (set_hit) d = '1;
      else if (clr_hit) d = '0;
      if (sw_wr)   d = (d & ~sw_wmask) | (sw_wdata & sw_wmask);
      if (rd_hit)  d = '0;
    end else begin
      if (sw_wr)   d = (d & ~sw_wmask) | (sw_wdata & sw_wmask);
      if (rd_hit)  d = '0;
      if (we_hit)  d = hw_wdata;
      if (set_hit) d = '1;
      else if (clr_hit) d = '0;
    end
    if (SINGLE_PULSE) d = d & (sw_wr ? sw_wmask : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= RESET_VAL;
    else        q <= d;
  end

  assign sw_rdata = q;
  assign hw_q     = q;
endmodule

module reg_field_chk #(
  parameter int unsigned      WIDTH         = 8,
  parameter logic [WIDTH-1:0] RESET_VAL     = '0,
  parameter bit               SW_PRECEDENCE = 1'b0,
  parameter bit               HAS_SET       = 1'b1,
  parameter bit               HAS_CLR       = 1'b0,
  parameter bit               WE_ACTIVE_LOW = 1'b0,
  parameter bit               CLEAR_ON_READ = 1'b0,
  parameter bit               SINGLE_PULSE  = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_wr,
  input logic [WIDTH-1:0] sw_wdata,
  input logic [WIDTH-1:0] sw_wmask,
  input logic             sw_rd,
  input logic [WIDTH-1:0] sw_rdata,
  input logic             hw_we,
  input logic [WIDTH-1:0] hw_wdata,
  input logic             hw_set,
  input logic             hw_clr,
  input logic [WIDTH-1:0] hw_q
);
  logic seen = 1'b0;
  logic prev_rst = 1'b0;
  logic we_on;
  assign we_on = (hw_we != WE_ACTIVE_LOW);

  always @(posedge clk) begin
    if (seen && prev_rst) p_reset_load_r1: assert (hw_q == RESET_VAL);
    seen     <= 1'b1;
    prev_rst <= !rst_n;
  end

  always_comb p_views_match_r3: assert (sw_rdata == hw_q);

  p_set_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_SET && !SW_PRECEDENCE && !SINGLE_PULSE && hw_set) |=> (hw_q == '1));

  p_clr_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_CLR && !HAS_SET && !SW_PRECEDENCE && !SINGLE_PULSE && hw_clr) |=> (hw_q == '0));

  p_sw_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (SW_PRECEDENCE && !SINGLE_PULSE && sw_wr && !(CLEAR_ON_READ && sw_rd))
      |=> ((hw_q & $past(sw_wmask)) == ($past(sw_wdata) & $past(sw_wmask))));

  p_pulse_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (SINGLE_PULSE && !sw_wr) |=> (hw_q == '0));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!SINGLE_PULSE && !sw_wr && !(CLEAR_ON_READ && sw_rd) && !we_on
      && !(HAS_SET && hw_set) && !(HAS_CLR && !HAS_SET && hw_clr)) |=> $stable(hw_q));
endmodule

bind reg_field reg_field_chk #(
  .WIDTH(WIDTH), .RESET_VAL(RESET_VAL), .SW_PRECEDENCE(SW_PRECEDENCE),
  .HAS_SET(HAS_SET), .HAS_CLR(HAS_CLR), .WE_ACTIVE_LOW(WE_ACTIVE_LOW),
  .CLEAR_ON_READ(CLEAR_ON_READ), .SINGLE_PULSE(SINGLE_PULSE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
  .sw_wmask(sw_wmask), .sw_rd(sw_rd), .sw_rdata(sw_rdata), .hw_we(hw_we),
  .hw_wdata(hw_wdata), .hw_set(hw_set), .hw_clr(hw_clr), .hw_q(hw_q)
);

// File: tb/test_reg_field.sv
module test_reg_field;
  localparam time PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_wr = 1'b0, sw_rd = 1'b0, hw_we = 1'b0, hw_set = 1'b0, hw_clr = 1'b0;
  logic [7:0] sw_wdata = '0, sw_wmask = '0, hw_wdata = '0;
  logic [7:0] ra, qa, rb, qb, rc, qc;
  logic [7:0] ea, eb, ec;
  int total = 0, bad = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  reg_field #(.WIDTH(8), .RESET_VAL(8'hA5), .SW_PRECEDENCE(0), .HAS_SET(1),
              .HAS_CLR(1), .WE_ACTIVE_LOW(0), .CLEAR_ON_READ(0), .SINGLE_PULSE(0))
  i_reg_field (.clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
    .sw_wmask(sw_wmask), .sw_rd(sw_rd), .sw_rdata(ra), .hw_we(hw_we),
    .hw_wdata(hw_wdata), .hw_set(hw_set), .hw_clr(hw_clr), .hw_q(qa));

  reg_field #(.WIDTH(8), .RESET_VAL(8'h3C), .SW_PRECEDENCE(1), .HAS_SET(0),
              .HAS_CLR(1), .WE_ACTIVE_LOW(1), .CLEAR_ON_READ(1), .SINGLE_PULSE(0))
  i_reg_field_b (.clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
    .sw_wmask(sw_wmask), .sw_rd(sw_rd), .sw_rdata(rb), .hw_we(~hw_we),
    .hw_wdata(hw_wdata), .hw_set(hw_set), .hw_clr(hw_clr), .hw_q(qb));

  reg_field #(.WIDTH(8), .RESET_VAL(8'h00), .SW_PRECEDENCE(0), .HAS_SET(1),
              .HAS_CLR(0), .WE_ACTIVE_LOW(0), .CLEAR_ON_READ(0), .SINGLE_PULSE(1))
  i_reg_field_c (.clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
    .sw_wmask(sw_wmask), .sw_rd(sw_rd), .sw_rdata(rc), .hw_we(hw_we),
    .hw_wdata(hw_wdata), .hw_set(hw_set), .hw_clr(hw_clr), .hw_q(qc));

  // we_on is the enable as intended by the bench, before any pin inversion
  function automatic logic [7:0] model(input logic [7:0] q, input bit swp,
      input bit has_set, input bit has_clr, input bit cor, input bit pulse,
      input logic wr, input logic [7:0] wd, input logic [7:0] wm, input logic rd,
      input logic we_on, input logic [7:0] hd, input logic st, input logic cl);
    logic [7:0] v, sw_v, hw_v;
    bit hw_any;
    v = q;
    hw_any = 0;
    hw_v = '0;
    if (we_on) begin hw_v = hd; hw_any = 1; end
    if (has_set && st) begin hw_v = 8'hFF; hw_any = 1; end
    else if (has_clr && !has_set && cl) begin hw_v = 8'h00; hw_any = 1; end
    if (swp) begin
      if (hw_any) v = hw_v;
      if (wr) v = (v & ~wm) | (wd & wm);
      if (cor && rd) v = '0;
    end else begin
      sw_v = wr ? ((v & ~wm) | (wd & wm)) : v;
      if (cor && rd) sw_v = '0;
      v = hw_any ? hw_v : sw_v;
    end
    if (pulse) v = v & (wr ? wm : 8'h00);
    return v;
  endfunction

  task automatic check(input string tag, input string who, input logic [7:0] got,
                       input logic [7:0] rd, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h exp %h", tag, who, got, exp);
    end
    total++;
    if (rd !== got) begin
      bad++;
      $display("FAIL R3 %s: sw_rdata %h exp %h", who, rd, got);
    end
  endtask

  task automatic check_all(input string ta, input string tb, input string tc);
    check(ta, "a", qa, ra, ea);
    check(tb, "b", qb, rb, eb);
    check(tc, "c", qc, rc, ec);
  endtask

  // drive at falling edge, model on rising edge, check at next falling edge
  task automatic step(input string tag, input logic wr, input logic [7:0] wd,
      input logic [7:0] wm, input logic rd, input logic we, input logic [7:0] hd,
      input logic st, input logic cl);
    sw_wr = wr; sw_wdata = wd; sw_wmask = wm; sw_rd = rd;
    hw_we = we; hw_wdata = hd; hw_set = st; hw_clr = cl;
    @(posedge clk);
    ea = model(ea, 0, 1, 1, 0, 0, wr, wd, wm, rd, we, hd, st, cl);
    eb = model(eb, 1, 0, 1, 1, 0, wr, wd, wm, rd, we, hd, st, cl);
    ec = model(ec, 0, 1, 0, 0, 1, wr, wd, wm, rd, we, hd, st, cl);
    @(negedge clk);
    if (tag == "RND") check_all("R7", "R8", "R10");
    else check_all(tag, tag, tag);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got hung exp finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    ea = 8'hA5; eb = 8'h3C; ec = 8'h00;
    check_all("R1", "R1", "R1");
    rst_n = 1'b1;
    step("R11", 0, 8'h00, 8'h00, 0, 0, 8'h00, 0, 0);
    step("R2",  1, 8'hFF, 8'h0F, 0, 0, 8'h00, 0, 0);
    step("R10", 0, 8'h00, 8'h00, 0, 0, 8'h00, 0, 0);
    step("R4",  0, 8'h00, 8'h00, 0, 1, 8'h5A, 0, 0);
    step("R5",  0, 8'h00, 8'h00, 0, 0, 8'h00, 1, 0);
    step("R6",  0, 8'h00, 8'h00, 0, 0, 8'h00, 0, 1);
    step("R7",  1, 8'h11, 8'hFF, 0, 1, 8'h22, 0, 0);
    step("R8",  1, 8'h0F, 8'h0F, 0, 0, 8'h00, 1, 1);
    step("R9",  0, 8'h00, 8'h00, 1, 0, 8'h00, 0, 0);
    step("R9",  1, 8'h77, 8'hFF, 1, 1, 8'h66, 0, 0);
    step("R2",  1, 8'hC3, 8'hF0, 0, 0, 8'h00, 0, 0);
    step("R11", 0, 8'h00, 8'h00, 0, 0, 8'h00, 0, 0);
    rst_n = 1'b0;
    @(posedge clk);
    ea = 8'hA5; eb = 8'h3C; ec = 8'h00;
    @(negedge clk);
    check_all("R1", "R1", "R1");
    rst_n = 1'b1;
    for (int i = 0; i < 600; i++) begin
      step("RND", ($urandom % 3) == 0, 8'($urandom), 8'($urandom), ($urandom % 5) == 0,
           ($urandom % 4) == 0, 8'($urandom), ($urandom % 7) == 0, ($urandom % 6) == 0);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule